// File: doc/BRIEF.md
# Grouped GPIO Interrupt Cause Unit

This block turns a 32-bit input word, already corrected for polarity by the GPIO port, into four interrupt request lines. Each pin can raise a request in two ways. In level mode the corrected input is the request while it stays high. In edge mode a low-to-high change of the corrected input sets a sticky cause bit, which stays set until software clears it. Two mask registers choose which mode, if any, is armed for each pin: a level enable and an edge enable. A 1 in a mask enables the source. Because the input is polarity-corrected, falling-edge or active-low detection is chosen upstream by setting that pin's polarity to 1.

The per-pin pending value is the OR of the enabled level source and the enabled edge source. The pending bits are ORed in groups of eight, pins 0-7, 8-15, 16-23 and 24-31, and each group drives one registered interrupt line. The full pending word is also available at a port, so an interrupt handler can find which pins need service. The cause register and the two mask registers sit on a simple register bus. Software acknowledges edge causes by writing a 0 to the bits it has handled.

Top module: `gpio_irq_aggregator`

## Requirements
- R1: After reset the edge cause register, the edge enable mask and the level enable mask all read zero, and every interrupt line is low. An input that is already high when reset ends records no edge.
- R2: The register map on an 8-bit address is as follows. The edge cause register is at 0x14. The edge enable mask is at 0x18 + MASK_OFS and the level enable mask at 0x1C + MASK_OFS. A write updates the addressed register at the next clock edge. Read data is combinational from the address and returns 0 for any other address, and writes to any other address change nothing.
- R3: A 0-to-1 transition of an input bit between two successive clock edges sets the matching edge cause bit, which then stays set when the input falls again.
- R4: A write to the edge cause register clears each bit where the write data holds 0 and leaves each bit where the write data holds 1 unchanged.
- R5: When a new rising transition and a clearing write hit the same cause bit on the same clock edge, the bit ends up set.
- R6: The pending word output is combinational and equals (input AND level mask) OR (edge cause AND edge mask). A mask bit of 0 keeps its source out of the pending word.
- R7: Interrupt line g is registered. It equals the OR of pending bits 8g to 8g+7 as they stood just before the previous clock edge, so it follows a pending change by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_level_i | input | 32 | Polarity-corrected input word |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational |
| pend_word_o | output | 32 | Masked pending word |
| irq_o | output | 4 | Interrupt line per group of eight pins |

## Verification
The pending word and the read data are combinational, so they are checked in the same cycle against the current inputs and the registered state. A rising input or a cause write shows in the cause register one clock after the edge that samples it. An interrupt line follows the pending word one further clock later, so an edge-sourced request reaches its line two edges after the input rises. The bench drives inputs just after the falling clock edge. At the next falling edge it compares every output against a model that it steps once per rising edge, so each result is sampled exactly in the cycle it is due.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int NPINS    = 32;
    localparam int GRP_SIZE = 8;
    localparam int NGRP     = NPINS / GRP_SIZE;
    localparam int ADDR_W   = 8;

    localparam logic [ADDR_W-1:0] CAUSE_ADDR = 8'h14;
    localparam logic [ADDR_W-1:0] EMASK_BASE = 8'h18;
    localparam logic [ADDR_W-1:0] LMASK_BASE = 8'h1C;

    typedef struct packed {
        logic [NPINS-1:0] cause;
        logic [NPINS-1:0] emask;
        logic [NPINS-1:0] lmask;
    } irq_regs_t;

endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = pin_i;
        rise_o = pin_i & ~prev_q;
    end

    // Reset to all ones: a line must be seen low before a rise counts.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/gpio_cause_regs.sv
module gpio_cause_regs
    import gpio_irq_pkg::*;
#(
    parameter int                NP       = NPINS,
    parameter logic [ADDR_W-1:0] MASK_OFS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NP-1:0]     wdata_i,
    input  logic [NP-1:0]     rise_i,
    output logic [NP-1:0]     cause_o,
    output logic [NP-1:0]     emask_o,
    output logic [NP-1:0]     lmask_o,
    output logic [NP-1:0]     rdata_o
);
    localparam logic [ADDR_W-1:0] EMASK_ADDR = EMASK_BASE + MASK_OFS;
    localparam logic [ADDR_W-1:0] LMASK_ADDR = LMASK_BASE + MASK_OFS;

    typedef struct packed {
        logic [NP-1:0] cause;
        logic [NP-1:0] emask;
        logic [NP-1:0] lmask;
    } regs_t;

    regs_t r_d, r_q;
    logic  hit_cause, hit_emask, hit_lmask;

    always_comb begin
        hit_cause = wr_i && (addr_i == CAUSE_ADDR);
        hit_emask = wr_i && (addr_i == EMASK_ADDR);
        hit_lmask = wr_i && (addr_i == LMASK_ADDR);

        r_d = r_q;
        // Write-zero-to-clear, with a new rise overriding the clear.
        if (hit_cause) r_d.cause = r_q.cause & wdata_i;
        r_d.cause = r_d.cause | rise_i;
        if (hit_emask) r_d.emask = wdata_i;
        if (hit_lmask) r_d.lmask = wdata_i;

        unique case (1'b1)
            (addr_i == CAUSE_ADDR): rdata_o = r_q.cause;
            (addr_i == EMASK_ADDR): rdata_o = r_q.emask;
            (addr_i == LMASK_ADDR): rdata_o = r_q.lmask;
            default:                rdata_o = '0;
        endcase

        cause_o = r_q.cause;
        emask_o = r_q.emask;
        lmask_o = r_q.lmask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/gpio_group_reduce.sv
module gpio_group_reduce #(
    parameter int NP   = 32,
    parameter int GS   = 8,
    localparam int NG  = NP / GS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] pend_i,
    output logic [NG-1:0] irq_o
);
    logic [NG-1:0] irq_d, irq_q;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        always_comb irq_d[g] = |pend_i[g*GS +: GS];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/gpio_irq_aggregator.sv
module gpio_irq_aggregator
    import gpio_irq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MASK_OFS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_level_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [NPINS-1:0]  bus_wdata_i,
    output logic [NPINS-1:0]  bus_rdata_o,
    output logic [NPINS-1:0]  pend_word_o,
    output logic [NGRP-1:0]   irq_o
);
    logic [NPINS-1:0] rise_w, cause_w, emask_w, lmask_w;

    gpio_edge_detect #(.W(NPINS)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_level_i),
        .rise_o (rise_w)
    );

    gpio_cause_regs #(.NP(NPINS), .MASK_OFS(MASK_OFS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .rise_i  (rise_w),
        .cause_o (cause_w),
        .emask_o (emask_w),
        .lmask_o (lmask_w),
        .rdata_o (bus_rdata_o)
    );

    always_comb pend_word_o = (pin_level_i & lmask_w) | (cause_w & emask_w);

    gpio_group_reduce #(.NP(NPINS), .GS(GRP_SIZE)) u_grp (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend_word_o),
        .irq_o  (irq_o)
    );
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
    import gpio_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NPINS-1:0]  pin_i,
    input logic              wr_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [NPINS-1:0]  wdata_i,
    input logic [NPINS-1:0]  cause_i,
    input logic [NPINS-1:0]  pend_i,
    input logic [NGRP-1:0]   irq_i
);
    logic [NPINS-1:0] seen_q;
    logic [NPINS-1:0] rise_c;
    logic [NGRP-1:0]  grp_c;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= '1;
        else        seen_q <= pin_i;
    end

    always_comb begin
        rise_c = pin_i & ~seen_q;
        for (int g = 0; g < NGRP; g++) grp_c[g] = |pend_i[g*GRP_SIZE +: GRP_SIZE];
    end

    // R3 / R5: a rise always lands in the cause register.
    assert_rise_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_c != '0) |=> ((cause_i & $past(rise_c)) == $past(rise_c)));

    // R3: no cause bit appears without a rise.
    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_i & ~$past(cause_i) & ~$past(rise_c)) == '0));

    // R4: zeros written to the cause register clear their bits.
    assert_write_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == CAUSE_ADDR) |=> ((cause_i & ~$past(wdata_i) & ~$past(rise_c)) == '0));

    // R4: bits not written keep their value unless a rise sets them.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == CAUSE_ADDR) |=> ((~cause_i & $past(cause_i)) == '0));

    // R7: each line follows the group OR one clock later.
    assert_irq_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_i == $past(grp_c)));
endmodule

bind gpio_irq_aggregator gpio_irq_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (pin_level_i),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .cause_i (cause_w),
    .pend_i  (pend_word_o),
    .irq_i   (irq_o)
);

// File: tb/tb_gpio_irq_aggregator.sv
module tb_gpio_irq_aggregator;
    localparam logic [7:0] OFS   = 8'h20;
    localparam logic [7:0] A_CAU = 8'h14;
    localparam logic [7:0] A_EM  = 8'h38;   // 0x18 + OFS
    localparam logic [7:0] A_LM  = 8'h3C;   // 0x1C + OFS
    localparam logic [7:0] A_BAD = 8'h18;   // unused once offset applies

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        wr = 1'b0;
    logic [7:0]  addr = A_CAU;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, pend;
    logic [3:0]  irq;

    int checks = 0;
    int fails  = 0;

    // Bench model state (post-edge)
    logic [31:0] m_cause, m_em, m_lm, m_prev;
    logic [3:0]  m_irq;

    always #5 clk = ~clk;

    gpio_irq_aggregator #(.MASK_OFS(OFS)) dut (
        .clk(clk), .rst_n(rst_n), .pin_level_i(pins),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .pend_word_o(pend), .irq_o(irq)
    );

    function automatic logic [31:0] f_pend(logic [31:0] p, logic [31:0] c,
                                          logic [31:0] em, logic [31:0] lm);
        return (p & lm) | (c & em);
    endfunction

    function automatic logic [3:0] f_grp(logic [31:0] pw);
        logic [3:0] r;
        for (int g = 0; g < 4; g++) r[g] = |pw[g*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] f_read(logic [7:0] a);
        if (a == A_CAU) return m_cause;
        if (a == A_EM)  return m_em;
        if (a == A_LM)  return m_lm;
        return '0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called right after a falling edge: compare, then drive and advance model.
    task automatic step(logic w, logic [7:0] a, logic [31:0] d, logic [31:0] p);
        logic [31:0] rise;
        chk("R2 read data", rdata, f_read(addr));
        chk("R6 pending word", pend, f_pend(pins, m_cause, m_em, m_lm));
        chk("R7 irq lines", {28'd0, irq}, {28'd0, m_irq});
        wr = w; addr = a; wdata = d; pins = p;
        rise   = p & ~m_prev;
        m_irq  = f_grp(f_pend(p, m_cause, m_em, m_lm));
        m_prev = p;
        if (w && a == A_CAU) m_cause = m_cause & d;
        m_cause = m_cause | rise;
        if (w && a == A_EM) m_em = d;
        if (w && a == A_LM) m_lm = d;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        pins = 32'h0000_00F0;   // high through reset: no edge (R1)
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_cause = '0; m_em = '0; m_lm = '0; m_prev = '1; m_irq = '0;
        @(posedge clk);
        m_prev = pins;
        @(negedge clk);
        // R1 reset state
        addr = A_CAU; #1 chk("R1 cause after reset", rdata, 32'h0);
        addr = A_EM;  #1 chk("R1 edge mask after reset", rdata, 32'h0);
        addr = A_LM;  #1 chk("R1 level mask after reset", rdata, 32'h0);
        chk("R1 irq after reset", {28'd0, irq}, 32'h0);
        addr = A_CAU;

        // R2 map: enable masks, unused address ignored
        step(1, A_EM, 32'hFFFF_FFFF, pins);
        step(1, A_BAD, 32'hDEAD_BEEF, pins);
        step(0, A_EM, '0, pins);
        chk("R2 edge mask at offset address", rdata, 32'hFFFF_FFFF);
        step(0, A_BAD, '0, pins);
        chk("R2 unused address reads zero", rdata, 32'h0);
        step(0, A_CAU, '0, pins);
        chk("R1 high-at-reset pin gives no edge", rdata, 32'h0);

        // R3 rise sets sticky cause; R7 irq two clocks after rise
        step(0, A_CAU, '0, 32'h0000_0100);
        chk("R3 cause set on rise", rdata, 32'h0000_0100);
        chk("R7 irq not yet", {28'd0, irq}, 32'h0);
        step(0, A_CAU, '0, 32'h0);
        chk("R7 irq group1 after one clock", {28'd0, irq}, 32'h2);
        chk("R3 cause sticky after fall", rdata, 32'h0000_0100);

        // R4 write-one keeps, write-zero clears
        step(1, A_CAU, 32'hFFFF_FFFF, 32'h0);
        chk("R4 write one keeps bit", rdata, 32'h0000_0100);
        step(1, A_CAU, 32'hFFFF_FEFF, 32'h0);
        chk("R4 write zero clears bit", rdata, 32'h0);

        // R5 rise and clear on the same edge
        step(1, A_CAU, 32'h0, 32'h0100_0000);
        chk("R5 rise beats clear", rdata, 32'h0100_0000);

        // R6 masked edge cause leaves pending low
        step(1, A_EM, 32'h0, 32'h0100_0000);
        chk("R6 edge mask zero hides cause", pend, 32'h0);
        step(1, A_LM, 32'h0000_00FF, 32'h0000_0011);
        chk("R6 level source follows input", pend, 32'h0000_0011);
        step(0, A_CAU, '0, 32'h0000_1011);
        chk("R6 level mask zero hides input", pend, 32'h0000_0011);

        // Randomised traffic
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom;
            logic [7:0]  a;
            logic [31:0] d = $urandom;
            logic [31:0] p = pins;
            case (r[2:0])
                3'd0, 3'd1: a = A_CAU;
                3'd2:       a = A_EM;
                3'd3:       a = A_LM;
                3'd4:       a = A_BAD;
                default:    a = 8'h10;
            endcase
            if (r[3] && a == A_CAU) d = d | $urandom;
            if (r[4]) p = p ^ (($urandom & $urandom) & $urandom);
            step(r[7:5] == 3'd0, a, d, p);
        end
        step(0, A_CAU, '0, pins);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule